// File: doc/BRIEF.md
# Amplitude to Decibel Converter

This block takes an unsigned linear magnitude, for example the amplitude from a vectoring rotation stage. It returns the level of that magnitude in decibels, 20·log10(x). The result is an unsigned fixed-point number with 8 integer bits and 4 fractional bits, so one output code is 1/16 dB.

No large direct logarithm table is used. The design works in three steps:

- It finds the position of the highest set bit. Each position is worth one octave, 20·log10(2) ≈ 6.0206 dB.
- The few bits just below that leading one, with the leading one itself implied and dropped, address a tiny table of 20·log10(1 + fraction). The table is computed at elaboration.
- The octave term and the table term are summed with eight guard bits and rounded once at the output.

Each table entry is taken at the centre of its fraction bin, which keeps the worst-case error near a quarter decibel. A zero input has no logarithm. It gives a code of zero and raises a separate flag. Samples enter with a valid strobe and leave three cycles later, one sample per cycle.

Top module: `db_conv`

## Requirements
- R1: For every nonzero input x, db_o/16 lies within 0.30 dB of 20·log10(x) (db_o is unsigned, 4 fractional bits).
- R2: Doubling a nonzero input that is below 2^23 raises db_o by 96 or 97 codes (one octave ≈ 96.33 codes).
- R3: Input bits more than 4 positions below the leading one have no effect: 0x800000 and 0x87FFFF give the same db_o.
- R4: An input of zero gives db_o = 0 with zero_o = 1. Any nonzero input gives zero_o = 0.
- R5: out_valid_o equals in_valid_i delayed by exactly 3 clock cycles. Back-to-back samples come out on consecutive cycles, in order.
- R6: While rst_ni is low, out_valid_o is 0. After release it stays 0 until a sample has passed the pipeline.
- R7: Boundary codes: an input of 1 gives db_o = 4 (0.25 dB), and an input of 0xFFFFFF gives db_o = 2310. No output exceeds 2311.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Input sample strobe |
| mag_i | input | 24 | Unsigned linear magnitude |
| out_valid_o | output | 1 | Result strobe, 3 cycles after in_valid_i |
| db_o | output | 12 | Level in 1/16 dB, unsigned |
| zero_o | output | 1 | Input of the current result was zero |

## Verification
The zero path and the normal sum-and-round path can be busy in neighbouring pipeline stages at the same time. A zero sample can then leave the adder in the same cycle that a nonzero neighbour is being looked up or normalized. The bench provokes this by streaming a nonzero magnitude, a zero, and twice the first magnitude on consecutive cycles. It judges the three results on consecutive cycles: the zero result must carry a code of 0 and a raised flag, and the two neighbours must be one octave apart with the flag low.

// File: rtl/db_conv_pkg.sv
package db_conv_pkg;
  // Bin-centre entry: 20*log10(1 + (idx+0.5)/2^addr_w), scaled by 2^frac
  function automatic int lut_entry(int idx, int addr_w, int frac);
    real f;
    f = (real'(idx) + 0.5) / real'(1 << addr_w);
    return int'($floor(20.0 * $log10(1.0 + f) * real'(1 << frac) + 0.5));
  endfunction

  function automatic int oct_const(int frac);
    return int'($floor(20.0 * $log10(2.0) * real'(1 << frac) + 0.5));
  endfunction
endpackage

// File: rtl/db_lod.sv
module db_lod #(
  parameter int IN_W   = 24,
  parameter int ADDR_W = 4,
  parameter int PW     = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              vld_i,
  input  logic [IN_W-1:0]   mag_i,
  output logic              vld_o,
  output logic              zero_o,
  output logic [PW-1:0]     pos_o,
  output logic [ADDR_W-1:0] mant_o
);
  logic [PW-1:0]   pos_c;
  logic [IN_W-1:0] norm_c;

  always_comb begin
    pos_c = '0;
    for (int i = 0; i < IN_W; i++)
      if (mag_i[i]) pos_c = PW'(i);
    norm_c = mag_i << (PW'(IN_W - 1) - pos_c);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_o  <= 1'b0;
      zero_o <= 1'b0;
      pos_o  <= '0;
      mant_o <= '0;
    end else begin
      vld_o  <= vld_i;
      zero_o <= (mag_i == '0);
      pos_o  <= pos_c;
      mant_o <= norm_c[IN_W-2 -: ADDR_W];  // implied leading one dropped
    end
  end

  p_lead_one_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_i && (mag_i != '0)) |=> (($past(mag_i) >> pos_o) == IN_W'(1)));
endmodule

// File: rtl/db_lut.sv
module db_lut #(
  parameter int ADDR_W = 4,
  parameter int FRAC_I = 12,
  parameter int PW     = 5,
  parameter int LUT_W  = 15
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              vld_i,
  input  logic              zero_i,
  input  logic [PW-1:0]     pos_i,
  input  logic [ADDR_W-1:0] mant_i,
  output logic              vld_o,
  output logic              zero_o,
  output logic [PW-1:0]     pos_o,
  output logic [LUT_W-1:0]  lut_o
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int OCT_K = db_conv_pkg::oct_const(FRAC_I);

  logic [LUT_W-1:0] tab [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_tab
    assign tab[g] = LUT_W'(db_conv_pkg::lut_entry(g, ADDR_W, FRAC_I));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_o  <= 1'b0;
      zero_o <= 1'b0;
      pos_o  <= '0;
      lut_o  <= '0;
    end else begin
      vld_o  <= vld_i;
      zero_o <= zero_i;
      pos_o  <= pos_i;
      lut_o  <= tab[mant_i];
    end
  end

  // fractional term must stay below one octave
  p_lut_sub_octave_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_o |-> (int'(lut_o) < OCT_K));
endmodule

// File: rtl/db_sum.sv
module db_sum #(
  parameter int IN_W   = 24,
  parameter int PW     = 5,
  parameter int LUT_W  = 15,
  parameter int FRAC_I = 12,
  parameter int GUARD  = 8,
  parameter int OUT_W  = 12
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             vld_i,
  input  logic             zero_i,
  input  logic [PW-1:0]    pos_i,
  input  logic [LUT_W-1:0] lut_i,
  output logic             vld_o,
  output logic             zero_o,
  output logic [OUT_W-1:0] db_o
);
  localparam int SUM_W  = OUT_W + GUARD + 1;
  localparam int OCT_K  = db_conv_pkg::oct_const(FRAC_I);
  localparam int MAX_DB = (IN_W * OCT_K) >> GUARD;

  logic [SUM_W-1:0] sum_c;
  logic [SUM_W-1:0] rnd_c;

  always_comb begin
    sum_c = SUM_W'(pos_i) * SUM_W'(OCT_K) + SUM_W'(lut_i);
    rnd_c = (sum_c + SUM_W'(1 << (GUARD - 1))) >> GUARD;  // single rounding
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_o  <= 1'b0;
      zero_o <= 1'b0;
      db_o   <= '0;
    end else begin
      vld_o  <= vld_i;
      zero_o <= zero_i;
      db_o   <= zero_i ? '0 : rnd_c[OUT_W-1:0];
    end
  end

  p_valid_pipe_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_o == $past(vld_i));
  p_zero_code_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vld_o && zero_o) |-> (db_o == '0));
  p_range_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_o |-> (int'(db_o) <= MAX_DB));
  p_reset_idle_r6: assert property (@(posedge clk_i)
    !rst_ni |-> !vld_o);
endmodule

// File: rtl/db_conv.sv
module db_conv #(
  parameter int IN_W   = 24,
  parameter int ADDR_W = 4,
  parameter int INT_W  = 8,
  parameter int FRAC_W = 4,
  parameter int GUARD  = 8
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     in_valid_i,
  input  logic [IN_W-1:0]          mag_i,
  output logic                     out_valid_o,
  output logic [INT_W+FRAC_W-1:0]  db_o,
  output logic                     zero_o
);
  localparam int OUT_W  = INT_W + FRAC_W;
  localparam int FRAC_I = FRAC_W + GUARD;
  localparam int PW     = $clog2(IN_W);
  localparam int LUT_W  = FRAC_I + 3;  // entries < 6.03 dB

  logic              s1_vld, s1_zero;
  logic [PW-1:0]     s1_pos;
  logic [ADDR_W-1:0] s1_mant;
  logic              s2_vld, s2_zero;
  logic [PW-1:0]     s2_pos;
  logic [LUT_W-1:0]  s2_lut;

  db_lod #(.IN_W(IN_W), .ADDR_W(ADDR_W), .PW(PW)) u_lod (
    .clk_i, .rst_ni, .vld_i(in_valid_i), .mag_i,
    .vld_o(s1_vld), .zero_o(s1_zero), .pos_o(s1_pos), .mant_o(s1_mant)
  );

  db_lut #(.ADDR_W(ADDR_W), .FRAC_I(FRAC_I), .PW(PW), .LUT_W(LUT_W)) u_lut (
    .clk_i, .rst_ni, .vld_i(s1_vld), .zero_i(s1_zero), .pos_i(s1_pos), .mant_i(s1_mant),
    .vld_o(s2_vld), .zero_o(s2_zero), .pos_o(s2_pos), .lut_o(s2_lut)
  );

  db_sum #(.IN_W(IN_W), .PW(PW), .LUT_W(LUT_W), .FRAC_I(FRAC_I),
           .GUARD(GUARD), .OUT_W(OUT_W)) u_sum (
    .clk_i, .rst_ni, .vld_i(s2_vld), .zero_i(s2_zero), .pos_i(s2_pos), .lut_i(s2_lut),
    .vld_o(out_valid_o), .zero_o, .db_o
  );
endmodule

// File: tb/db_conv_test.sv
module db_conv_test;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        in_valid_i = 1'b0;
  logic [23:0] mag_i = '0;
  logic        out_valid_o;
  logic [11:0] db_o;
  logic        zero_o;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  db_conv uut (.clk_i(clk), .rst_ni, .in_valid_i, .mag_i, .out_valid_o, .db_o, .zero_o);

  localparam int NV = 12;
  localparam logic [23:0] VEC [NV] = '{24'h000001, 24'h000002, 24'h000003, 24'h000010,
                                       24'h00001F, 24'h000100, 24'h001234, 24'h0ABCDE,
                                       24'h7FFFFF, 24'h800000, 24'hC00000, 24'hFFFFFF};

  task automatic chk(string req, int got, int exp, bit ok);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic chk_db(string req, logic [23:0] x, logic [11:0] got);
    real e, g;
    e = 20.0 * $log10(real'(x));
    g = real'(got) / 16.0;
    chk(req, int'(got), int'($floor(e * 16.0 + 0.5)), (g - e <= 0.30) && (e - g <= 0.30));
  endtask

  // one sample in, result read 3 cycles later
  task automatic run1(logic [23:0] x, output logic [11:0] r, output logic z, output logic v);
    @(negedge clk); mag_i = x; in_valid_i = 1'b1;
    @(negedge clk); in_valid_i = 1'b0;
    @(negedge clk);
    chk("R5 early", int'(out_valid_o), 0, out_valid_o == 1'b0);
    @(negedge clk);
    r = db_o; z = zero_o; v = out_valid_o;
  endtask

  initial begin
    #4000000;
    if (!done) begin
      n_vec++; n_bad++;
      $display("FAIL watchdog: got hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    logic [11:0] r, r2;
    logic z, v;
    repeat (3) @(negedge clk);
    chk("R6 in reset", int'(out_valid_o), 0, out_valid_o == 1'b0);
    rst_ni = 1'b1;
    repeat (2) @(negedge clk);
    chk("R6 after release", int'(out_valid_o), 0, out_valid_o == 1'b0);

    for (int i = 0; i < NV; i++) begin
      run1(VEC[i], r, z, v);
      chk("R5 valid", int'(v), 1, v == 1'b1);
      chk("R4 flag low", int'(z), 0, z == 1'b0);
      chk_db("R1", VEC[i], r);
    end

    run1(24'd1, r, z, v);
    chk("R7 min", int'(r), 4, r == 12'd4);
    run1(24'hFFFFFF, r, z, v);
    chk("R7 max", int'(r), 2310, r == 12'd2310);

    run1(24'd0, r, z, v);
    chk("R4 zero code", int'(r), 0, r == 12'd0);
    chk("R4 zero flag", int'(z), 1, z == 1'b1);

    run1(24'h001234, r, z, v);
    run1(24'h002468, r2, z, v);
    chk("R2 octave", int'(r2) - int'(r), 96, (int'(r2) - int'(r) == 96) || (int'(r2) - int'(r) == 97));

    run1(24'h800000, r, z, v);
    run1(24'h87FFFF, r2, z, v);
    chk("R3 low bits", int'(r2), int'(r), r2 == r);

    // stream: nonzero, zero, doubled on consecutive cycles
    @(negedge clk); mag_i = 24'h000040; in_valid_i = 1'b1;
    @(negedge clk); mag_i = 24'h000000;
    @(negedge clk); mag_i = 24'h000080;
    @(negedge clk); in_valid_i = 1'b0;
    chk("R5 stream a", int'(out_valid_o), 1, out_valid_o == 1'b1);
    chk_db("R1 stream a", 24'h000040, db_o);
    r = db_o;
    @(negedge clk);
    chk("R4 stream zero", int'(db_o), 0, out_valid_o && zero_o && db_o == 12'd0);
    @(negedge clk);
    chk("R4 stream flag", int'(zero_o), 0, out_valid_o && !zero_o);
    chk("R2 stream", int'(db_o) - int'(r), 96, (int'(db_o) - int'(r) == 96) || (int'(db_o) - int'(r) == 97));
    @(negedge clk);
    chk("R5 stream end", int'(out_valid_o), 0, out_valid_o == 1'b0);

    rst_ni = 1'b0;
    @(negedge clk);
    chk("R6 reset again", int'(out_valid_o), 0, out_valid_o == 1'b0);

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule